// File: doc/BRIEF.md
# Calendar Counter with Alarm and Two-Phase Update

This block holds a wall-clock calendar (seconds, minutes, hours, weekday, day of month, month, two-digit year) as binary counters and moves it forward by one second on each qualified 1 Hz tick. Every second starts a two-phase update. The first phase advances the internal time and raises an update-in-progress indicator. After a fixed number of delay ticks, the second phase copies the time into a bank of host-visible bytes, checks the alarm, raises the update-ended flag and drops the indicator.

The visible bytes are encoded as BCD or plain binary, with hours in 24-hour or 12-hour form, as the mode inputs select. A load strobe writes a complete new time at once. The block decodes the strobe's bytes under the same modes into the internal counters, and places them verbatim in the visible bank.

The update sequencer has two states. It goes from `UPD_IDLE` to `UPD_WAIT` on a qualified second tick, and from `UPD_WAIT` back to `UPD_IDLE` on the delay tick that completes the wait. The host decoder that would sit in front of this block is not part of it.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the visible bytes read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00, and `uip`, `uf`, `af`, `irqf` and `irq` are all 0.
- R2: A second tick takes effect only when `osc_sel` equals 3'b010. With any other value the tick changes neither the time nor `uip`, and no update completes.
- R3: A qualified tick advances the internal time by one second and, in the next cycle, sets `uip` unless `set_mode` is 1. If `set_mode` is 1, `uip` stays 0.
- R4: On the DLY_TICKS-th `dly_tick` after the tick (default 8), the block does the following. It copies the time into the visible bytes unless `set_mode` is 1, sets `uf`, clears `uip`, and sets `irqf` if `uie` is 1. Until then the visible bytes keep their old values.
- R5: At the second phase the alarm hits when all three alarm bytes match. An alarm byte matches when its bits 7:6 are 2'b11, or when its decoded value (BCD or binary per `bin_mode`, hour compared as 0 to 23) equals the current field. A hit sets `af`, and also sets `irqf` if `aie` is 1.
- R6: With `bin_mode` 0, a visible byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. With `bin_mode` 1, a visible byte holds the plain binary value.
- R7: With `hr24` 0, the hour byte shows 1 to 12 with bit 7 set for hours 12 to 23, and hour 0 shows as 12. On load, the decoded hour is taken modulo 12, and 12 is added if bit 7 is set.
- R8: Seconds wrap at 60 into minutes, minutes wrap at 60 into hours, and hours wrap at 24 into the next day. The weekday runs from 1 to 7 and wraps to 1.
- R9: The day wraps to 1 past the month's length, where months have 31,28,31,30,31,30,31,31,30,31,30,31 days. February has 29 days when year BASE_YEAR+offset is a multiple of 4 that is either not a multiple of 100 or a multiple of 400. The month wraps from 12 to 1 into the year, and the year offset wraps from 99 to 0.
- R10: A load replaces the internal time in the same cycle, and the visible bytes show the loaded bytes the next cycle. A tick in the load cycle is ignored: no increment and no update cycle.
- R11: `flag_clr` clears `uf`, `af` and `irqf`. A flag set by the second phase in the same cycle wins. `irq` always equals `irqf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| dly_tick | input | 1 | Delay timebase pulse for the second phase |
| osc_sel | input | 3 | Oscillator select; 3'b010 runs the clock |
| set_mode | input | 1 | Freeze visible bytes and suppress `uip` |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| uie | input | 1 | Update-ended interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clear `uf`, `af`, `irqf` |
| alarm_sec | input | 8 | Seconds alarm byte |
| alarm_min | input | 8 | Minutes alarm byte |
| alarm_hr | input | 8 | Hours alarm byte |
| load | input | 1 | Time load strobe |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hr | input | 8 | Hours to load (bit 7 = PM in 12-hour mode) |
| ld_wday | input | 8 | Weekday to load (1..7) |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load (1..12) |
| ld_year | input | 8 | Year offset to load (0..99) |
| q_sec | output | 8 | Visible seconds |
| q_min | output | 8 | Visible minutes |
| q_hr | output | 8 | Visible hours |
| q_wday | output | 8 | Visible weekday |
| q_mday | output | 8 | Visible day of month |
| q_mon | output | 8 | Visible month |
| q_year | output | 8 | Visible year offset |
| uip | output | 1 | Update in progress |
| uf | output | 1 | Update-ended flag |
| af | output | 1 | Alarm flag |
| irqf | output | 1 | Interrupt request flag |
| irq | output | 1 | Interrupt request line |

## Verification
A wrong internal count stays out of sight until the next second phase copies it into the visible bytes. A carry error therefore shows exactly DLY_TICKS delay ticks after the tick that caused it, and the vectors stage each rollover so that one second exposes it. A sequencer stuck in `UPD_WAIT` shows at once as `uip` held high and `uf` never rising. A flaw in the alarm or in a mode decode shows in `af` and `irqf` at that same completing edge.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    typedef enum logic {
        UPD_IDLE,
        UPD_WAIT
    } upd_state_e;

    // binary value to visible byte
    function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    // visible byte to binary value
    function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
        logic [7:0] t;
        t = 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
        return bin ? b[6:0] : t[6:0];
    endfunction

    function automatic logic is_leap(input int unsigned y);
        return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
`timescale 1ns/1ps
module rtc_time_counter
    import rtc_cal_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  cal_t load_val,
    output cal_t now
);

    localparam cal_t RESET_TIME = '{yr: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                                    hr: 5'd0, min: 6'd0, sec: 6'd0};

    cal_t       nxt;
    logic       leap;
    logic [4:0] dim;

    always_comb begin
        leap = is_leap(32'(BASE_YEAR) + 32'(now.yr));
        dim  = month_len(now.mon, leap);
        nxt  = now;
        if (now.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            if (now.min >= 6'd59) begin
                nxt.min = 6'd0;
                if (now.hr >= 5'd23) begin
                    nxt.hr   = 5'd0;
                    nxt.wday = (now.wday >= 3'd7) ? 3'd1 : now.wday + 3'd1;
                    if (now.mday >= dim) begin
                        nxt.mday = 5'd1;
                        if (now.mon >= 4'd12) begin
                            nxt.mon = 4'd1;
                            nxt.yr  = (now.yr >= 7'd99) ? 7'd0 : now.yr + 7'd1;
                        end else begin
                            nxt.mon = now.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = now.mday + 5'd1;
                    end
                end else begin
                    nxt.hr = now.hr + 5'd1;
                end
            end else begin
                nxt.min = now.min + 6'd1;
            end
        end else begin
            nxt.sec = now.sec + 6'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     now <= RESET_TIME;
        else if (load)  now <= load_val;
        else if (step)  now <= nxt;
    end

    a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(now));
    a_r10_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (now == $past(load_val)));
    a_r3_step_moves_time: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (now != $past(now)));

endmodule

// File: rtl/rtc_update_seq.sv
`timescale 1ns/1ps
module rtc_update_seq
    import rtc_cal_pkg::*;
#(
    parameter int DLY_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dly_tick,
    input  logic set_mode,
    output logic uip,
    output logic done
);

    localparam int CW = (DLY_TICKS > 1) ? $clog2(DLY_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

    upd_state_e      state, state_n;
    logic [CW-1:0]   cnt;

    assign done = (state == UPD_WAIT) && dly_tick && (cnt == LAST);

    always_comb begin
        state_n = state;
        unique case (state)
            UPD_IDLE: if (start) state_n = UPD_WAIT;
            UPD_WAIT: if (done)  state_n = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= UPD_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            uip <= 1'b0;
        end else begin
            unique case (state)
                UPD_IDLE: if (start) begin
                    cnt <= '0;
                    uip <= !set_mode;
                end
                UPD_WAIT: if (done) begin
                    uip <= 1'b0;
                end else if (dly_tick) begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    a_r4_uip_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !uip);
    a_r3_uip_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(start));

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  logic [7:0] alarm_sec,
    input  logic [7:0] alarm_min,
    input  logic [7:0] alarm_hr,
    input  logic       bin_mode,
    input  cal_t       now,
    output logic       hit
);

    logic m_sec, m_min, m_hr;

    always_comb begin
        m_sec = (alarm_sec[7:6] == 2'b11) || (dec_field(alarm_sec, bin_mode) == 7'(now.sec));
        m_min = (alarm_min[7:6] == 2'b11) || (dec_field(alarm_min, bin_mode) == 7'(now.min));
        m_hr  = (alarm_hr[7:6]  == 2'b11) || (dec_field(alarm_hr,  bin_mode) == 7'(now.hr));
        hit   = m_sec && m_min && m_hr;
    end

endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int       BASE_YEAR = 2000,
    parameter int       DLY_TICKS = 8,
    parameter bit [2:0] OSC_RUN   = 3'b010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       dly_tick,
    input  logic [2:0] osc_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic       uie,
    input  logic       aie,
    input  logic       flag_clr,
    input  logic [7:0] alarm_sec,
    input  logic [7:0] alarm_min,
    input  logic [7:0] alarm_hr,
    input  logic       load,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hr,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic [7:0] q_sec,
    output logic [7:0] q_min,
    output logic [7:0] q_hr,
    output logic [7:0] q_wday,
    output logic [7:0] q_mday,
    output logic [7:0] q_mon,
    output logic [7:0] q_year,
    output logic       uip,
    output logic       uf,
    output logic       af,
    output logic       irqf,
    output logic       irq
);

    cal_t       now, load_val;
    logic       step, upd_done, alarm_hit;
    logic [6:0] ld_h_raw, ld_h;
    logic [4:0] h_mod, h12;
    logic [7:0] enc_hr, enc12;

    assign step = sec_tick && (osc_sel == OSC_RUN) && !load;
    assign irq  = irqf;

    // decode load bytes under the current modes
    always_comb begin
        ld_h_raw = dec_field({1'b0, ld_hr[6:0]}, bin_mode);
        if (hr24) ld_h = ld_h_raw;
        else      ld_h = (ld_h_raw % 7'd12) + (ld_hr[7] ? 7'd12 : 7'd0);
        load_val.sec  = 6'(dec_field(ld_sec,  bin_mode));
        load_val.min  = 6'(dec_field(ld_min,  bin_mode));
        load_val.hr   = ld_h[4:0];
        load_val.wday = 3'(dec_field(ld_wday, bin_mode));
        load_val.mday = 5'(dec_field(ld_mday, bin_mode));
        load_val.mon  = 4'(dec_field(ld_mon,  bin_mode));
        load_val.yr   = dec_field(ld_year, bin_mode);
    end

    // encode the hour for the visible bank
    always_comb begin
        h_mod  = now.hr % 5'd12;
        h12    = (h_mod == 5'd0) ? 5'd12 : h_mod;
        enc12  = enc_field(7'(h12), bin_mode);
        enc_hr = hr24 ? enc_field(7'(now.hr), bin_mode)
                      : {(now.hr >= 5'd12), enc12[6:0]};
    end

    rtc_time_counter #(.BASE_YEAR(BASE_YEAR)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load),
        .load_val (load_val),
        .now      (now)
    );

    rtc_update_seq #(.DLY_TICKS(DLY_TICKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (step),
        .dly_tick (dly_tick),
        .set_mode (set_mode),
        .uip      (uip),
        .done     (upd_done)
    );

    rtc_alarm_match u_alarm (
        .alarm_sec (alarm_sec),
        .alarm_min (alarm_min),
        .alarm_hr  (alarm_hr),
        .bin_mode  (bin_mode),
        .now       (now),
        .hit       (alarm_hit)
    );

    // visible bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sec  <= 8'h00; q_min  <= 8'h00; q_hr  <= 8'h00;
            q_wday <= 8'h01; q_mday <= 8'h01; q_mon <= 8'h01; q_year <= 8'h00;
        end else if (load) begin
            q_sec  <= ld_sec;  q_min  <= ld_min;  q_hr  <= ld_hr;
            q_wday <= ld_wday; q_mday <= ld_mday; q_mon <= ld_mon; q_year <= ld_year;
        end else if (upd_done && !set_mode) begin
            q_sec  <= enc_field(7'(now.sec),  bin_mode);
            q_min  <= enc_field(7'(now.min),  bin_mode);
            q_hr   <= enc_hr;
            q_wday <= enc_field(7'(now.wday), bin_mode);
            q_mday <= enc_field(7'(now.mday), bin_mode);
            q_mon  <= enc_field(7'(now.mon),  bin_mode);
            q_year <= enc_field(now.yr,       bin_mode);
        end
    end

    // flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf <= 1'b0; af <= 1'b0; irqf <= 1'b0;
        end else begin
            uf   <= (uf   && !flag_clr) || upd_done;
            af   <= (af   && !flag_clr) || (upd_done && alarm_hit);
            irqf <= (irqf && !flag_clr) || (upd_done && (uie || (aie && alarm_hit)));
        end
    end

    a_r5_alarm_at_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(upd_done));
    a_r4_uf_with_uip_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf) |-> !uip);
    a_r11_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !upd_done) |=> (!uf && !af && !irqf));
    a_r10_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_sec == $past(ld_sec) && q_hr == $past(ld_hr)));

endmodule

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 0, dly_tick = 0, set_mode = 0, bin_mode = 0, hr24 = 1;
    logic       uie = 0, aie = 0, flag_clr = 0, load = 0;
    logic [2:0] osc_sel = 3'b010;
    logic [7:0] alarm_sec = 0, alarm_min = 0, alarm_hr = 0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hr = 0, ld_wday = 1, ld_mday = 1, ld_mon = 1, ld_year = 0;
    logic [7:0] q_sec, q_min, q_hr, q_wday, q_mday, q_mon, q_year;
    logic       uip, uf, af, irqf, irq;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    rtc_calendar_core uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .dly_tick(dly_tick),
        .osc_sel(osc_sel), .set_mode(set_mode), .bin_mode(bin_mode), .hr24(hr24),
        .uie(uie), .aie(aie), .flag_clr(flag_clr),
        .alarm_sec(alarm_sec), .alarm_min(alarm_min), .alarm_hr(alarm_hr),
        .load(load), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr),
        .ld_wday(ld_wday), .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year),
        .q_sec(q_sec), .q_min(q_min), .q_hr(q_hr), .q_wday(q_wday),
        .q_mday(q_mday), .q_mon(q_mon), .q_year(q_year),
        .uip(uip), .uf(uf), .af(af), .irqf(irqf), .irq(irq)
    );

    // {sec,min,hr,wday,mday,mon,year} loaded, then expected after one second (BCD, 24h)
    localparam logic [111:0] VEC [9] = '{
        {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
        {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
        {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
        {56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24},
        {56'h59_59_23_05_30_04_24, 56'h00_00_00_06_01_05_24},
        {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00},
        {56'h59_59_23_06_31_01_05, 56'h00_00_00_07_01_02_05},
        {56'h09_59_09_01_15_06_10, 56'h10_59_09_01_15_06_10},
        {56'h59_59_09_01_15_06_10, 56'h00_00_10_01_15_06_10}
    };

    function automatic logic [55:0] vis();
        return {q_sec, q_min, q_hr, q_wday, q_mday, q_mon, q_year};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) sec_tick = 1;
        @(negedge clk) sec_tick = 0;
    endtask

    task automatic pulse_dly(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) dly_tick = 1;
            @(negedge clk) dly_tick = 0;
        end
    endtask

    task automatic one_second();
        pulse_tick();
        pulse_dly(8);
    endtask

    task automatic clear_flags();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
    endtask

    task automatic load_time(input logic [55:0] b);
        @(negedge clk);
        {ld_sec, ld_min, ld_hr, ld_wday, ld_mday, ld_mon, ld_year} = b;
        load = 1;
        @(negedge clk) load = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset visible", 64'(vis()), 64'h00_00_00_01_01_01_00);
        chk("R1 reset flags", 64'({uip, uf, af, irqf, irq}), 64'h0);

        // rollover vectors
        for (int i = 0; i < 9; i++) begin
            load_time(VEC[i][111:56]);
            one_second();
            chk($sformatf("R8 R9 vector %0d", i), 64'(vis()), 64'(VEC[i][55:0]));
        end
        clear_flags();

        // two-phase timing
        load_time(56'h56_34_12_03_10_07_20);
        chk("R10 loaded bytes visible", 64'(vis()), 64'h56_34_12_03_10_07_20);
        pulse_tick();
        chk("R3 uip raised", 64'(uip), 64'h1);
        pulse_dly(7);
        chk("R4 visible held before final delay tick", 64'(q_sec), 64'h56);
        chk("R4 uip held before final delay tick", 64'(uip), 64'h1);
        pulse_dly(1);
        chk("R4 seconds copied", 64'(q_sec), 64'h57);
        chk("R4 uip/uf/irqf after update", 64'({uip, uf, irqf}), 64'b010);
        clear_flags();
        chk("R11 uf cleared", 64'(uf), 64'h0);
        uie = 1;
        one_second();
        chk("R4 irqf with uie", 64'({irqf, irq, q_sec}), {48'h0, 2'b11, 8'h58, 6'h0} >> 6);
        clear_flags();
        chk("R11 irq cleared", 64'({irqf, irq}), 64'h0);
        uie = 0;

        // oscillator gate
        osc_sel = 3'b000;
        pulse_tick();
        chk("R2 no uip when stopped", 64'(uip), 64'h0);
        pulse_dly(8);
        chk("R2 time and uf frozen", 64'({q_sec, 7'h0, uf}), {q_sec == 8'h58 ? 8'h58 : 8'hEE, 8'h0});
        osc_sel = 3'b010;
        one_second();
        chk("R2 count resumes", 64'(q_sec), 64'h59);

        // set mode
        clear_flags();
        set_mode = 1;
        pulse_tick();
        chk("R3 no uip in set mode", 64'(uip), 64'h0);
        pulse_dly(8);
        chk("R4 visible frozen in set mode", 64'(q_sec), 64'h59);
        chk("R4 uf set in set mode", 64'(uf), 64'h1);
        set_mode = 0;
        clear_flags();
        one_second();
        chk("R3 internal time kept counting", 64'({q_min, q_sec}), 64'h3501);

        // load beats tick
        clear_flags();
        @(negedge clk);
        {ld_sec, ld_min, ld_hr, ld_wday, ld_mday, ld_mon, ld_year} = 56'h20_00_08_01_01_01_01;
        load = 1; sec_tick = 1;
        @(negedge clk) load = 0; sec_tick = 0;
        chk("R10 tick ignored on load", 64'({q_sec, 7'h0, uip}), 64'h2000);
        pulse_dly(8);
        chk("R10 no update after ignored tick", 64'(uf), 64'h0);
        one_second();
        chk("R10 loaded value not incremented", 64'(q_sec), 64'h21);

        // alarm
        aie = 1;
        alarm_sec = 8'h30; alarm_min = 8'h20; alarm_hr = 8'h10;
        load_time(56'h29_20_10_01_01_01_01);
        clear_flags();
        one_second();
        chk("R5 exact alarm hit", 64'({af, irqf}), 64'b11);
        alarm_hr = 8'h11;
        load_time(56'h29_20_10_01_01_01_01);
        clear_flags();
        one_second();
        chk("R5 alarm miss", 64'({af, irqf}), 64'b00);
        alarm_sec = 8'hC0; alarm_min = 8'hFF; alarm_hr = 8'hC5;
        load_time(56'h29_20_10_01_01_01_01);
        clear_flags();
        one_second();
        chk("R5 wildcard alarm hit", 64'({af, irqf}), 64'b11);
        aie = 0;
        load_time(56'h29_20_10_01_01_01_01);
        clear_flags();
        one_second();
        chk("R5 hit without aie", 64'({af, irqf}), 64'b10);

        // binary mode
        bin_mode = 1;
        load_time(56'h3B_0A_05_01_01_01_00);
        one_second();
        chk("R6 binary rollover", 64'({q_sec, q_min, q_hr}), 64'h00_0B_05);
        bin_mode = 0;
        load_time(56'h49_00_05_01_01_01_00);
        one_second();
        chk("R6 bcd digits", 64'(q_sec), 64'h50);

        // 12-hour mode
        hr24 = 0;
        load_time(56'h59_59_92_01_01_01_00);
        one_second();
        chk("R7 12 PM to 1 PM", 64'(q_hr), 64'h81);
        load_time(56'h59_59_11_01_01_01_00);
        one_second();
        chk("R7 11 AM to 12 PM", 64'(q_hr), 64'h92);
        load_time(56'h00_00_12_01_01_01_00);
        one_second();
        chk("R7 midnight shows 12", 64'({q_hr, q_sec}), 64'h1201);
        hr24 = 1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule